// File: doc/BRIEF.md
# LCD Panel Scan Timing Generator

This block produces the scan strobes for an LCD panel from a faster controller clock. It makes a shift-clock strobe, a horizontal sync, a vertical sync and an output enable. Each of these four pins has its own polarity bit. A prescaler divides the controller clock by a rate factor K of 1, 2 or 3. K is chosen from the panel configuration. A line counter steps once per shift period, and a frame counter steps once per line. Every line opens with a fixed 12-period horizontal sync. The data slots follow it, then the wait periods between lines. The frame is built from vertical-sync lines, data lines and wait lines between frames.

A pixel fetch path uses the `pix_x` and `line_y` position outputs. These tell it which bus word is being shifted out while the output enable is active. The configuration inputs are captured while `enable` is low and again at the final shift period of each frame. A write made during a frame therefore takes effect only from the next frame. Configuration should be applied at least two cycles before `enable` is raised.

Top module: `lcd_scan_timing`

## Requirements
- R1: The shift strobe `lcd_shift` is active for one controller cycle every K cycles. `cfg_bpp` uses the encoding 0=1, 1=2, 2=4 and 3=8 bits per pixel. K=3 for a passive (`cfg_tft`=0) colour panel at 4 bpp with an 8-bit bus (`cfg_wide`=1) in single scan. K=2 for the same colour mode with an 8-bit bus in dual scan, or with a 4-bit bus in single scan. K=1 for every other configuration.
- R2: A line lasts K·(S + 12 + `cfg_wbl` + N) controller cycles. S is the number of data slots. N=7 for a passive monochrome panel on a 4-bit bus at 2 or 4 bpp, and N=5 otherwise.
- R3: The number of data slots is S = P'/W. P' is `cfg_ppl`, doubled when `cfg_dual`=1. W is 1 for a TFT panel, 8 for a passive panel with `cfg_wide`=1, and 4 for a passive panel with `cfg_wide`=0. The data line count D is `cfg_lpp`, halved in dual scan.
- R4: A frame has F + D + `cfg_wbf` lines, and its length is that number times the line length. F is `cfg_vpw`+1 on a TFT panel and 0 on a passive panel.
- R5: On a TFT panel, VSYNC is active for the first `cfg_vpw`+1 lines (1 to 16) and never overlaps the output enable. On a passive panel, VSYNC is active during the first line of the frame.
- R6: HSYNC is active for the first 12 shift periods of every line, and the output enable is inactive during it.
- R7: The output enable is active only on data lines, during the S shift periods that follow HSYNC. Exactly S·D shift strobes fall inside it per frame.
- R8: Each output pin is driven to its polarity bit when active and to the inverse of that bit when inactive. A polarity bit of 1 means active high.
- R9: While the output enable is active, `pix_x` counts 0..S-1 within the line and `line_y` counts 0..D-1 across the data lines.
- R10: A configuration change made during a frame leaves that frame's timing unchanged. The change applies from the next frame.
- R11: While `enable` is low, all four pins are at their inactive level, the positions read 0, and the counters restart from the frame start when `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable |
| cfg_tft | input | 1 | 1 = active (TFT) panel, 0 = passive |
| cfg_dual | input | 1 | Dual-scan passive panel |
| cfg_color | input | 1 | Colour passive panel |
| cfg_wide | input | 1 | Passive bus width: 1 = 8 bits, 0 = 4 bits |
| cfg_bpp | input | 2 | Bits per pixel code (0=1, 1=2, 2=4, 3=8) |
| cfg_ppl | input | PIX_W | Pixels per line |
| cfg_lpp | input | LINE_W | Lines per panel |
| cfg_vpw | input | VPW_W | Vertical sync width minus one, in lines |
| cfg_wbl | input | WBL_W | Wait periods between lines |
| cfg_wbf | input | WBF_W | Wait lines between frames |
| cfg_pol_shift | input | 1 | Shift strobe active level |
| cfg_pol_hs | input | 1 | HSYNC active level |
| cfg_pol_vs | input | 1 | VSYNC active level |
| cfg_pol_oe | input | 1 | Output enable active level |
| lcd_shift | output | 1 | Shift clock strobe |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_oe | output | 1 | Output enable |
| pix_x | output | PIX_W+1 | Data slot index within the line |
| line_y | output | LINE_W | Data line index within the frame |

## Verification
The configuration reload and the frame wrap occur in the same cycle: the last shift period of the last line. That cycle also wraps the prescaler and both counters. The bench provokes this by rewriting the wait-between-lines field partway through a frame. It then measures the controller cycles between VSYNC onsets for two frames: the frame in progress must keep the old length, and the next frame must show the new one. On passive panels, VSYNC and the output enable also overlap on the first line. The bench judges this by counting the enabled data cycles per frame against the expected total.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int HS_SLOTS = 12;  // fixed sync overhead per line, in shift periods
  localparam int KW       = 2;   // width of the rate factor

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } bpp_e;

  // Controller clocks per shift period.
  function automatic int rate_k(logic tft, logic color, logic wide, logic dual,
                                logic [1:0] bpp);
    if (!tft && color && (bpp == BPP4)) begin
      if (wide && !dual) return 3;
      if ((wide && dual) || (!wide && !dual)) return 2;
    end
    return 1;
  endfunction

  // Extra wait periods added to the programmed line wait.
  function automatic int lead_pad(logic tft, logic color, logic wide,
                                  logic [1:0] bpp);
    if (!tft && !color && !wide && ((bpp == BPP2) || (bpp == BPP4))) return 7;
    return 5;
  endfunction

  // Bus words shifted per line.
  function automatic int data_slots(int ppl, logic tft, logic wide, logic dual);
    int p;
    p = dual ? (ppl * 2) : ppl;
    if (tft) return p;
    return wide ? (p / 8) : (p / 4);
  endfunction

  // Data lines per frame.
  function automatic int line_rows(int lpp, logic dual);
    return dual ? (lpp / 2) : lpp;
  endfunction

endpackage

// File: rtl/lcd_rate_div.sv
module lcd_rate_div #(
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [KW-1:0] k,
  output logic          tick
);
  logic [KW-1:0] cnt;

  assign tick = run && (cnt == (k - KW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + KW'(1);
  end
endmodule

// File: rtl/lcd_span_ctr.sv
module lcd_span_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = (cnt == (limit - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (step)  cnt <= last ? '0 : (cnt + W'(1));
  end
endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive #(
  parameter int N = 4
) (
  input  logic [N-1:0] act,
  input  logic [N-1:0] pol,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pin[i] = act[i] ? pol[i] : ~pol[i];
  end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int VPW_W  = 4,
  parameter int WBL_W  = 8,
  parameter int WBF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_tft,
  input  logic              cfg_dual,
  input  logic              cfg_color,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_bpp,
  input  logic [PIX_W-1:0]  cfg_ppl,
  input  logic [LINE_W-1:0] cfg_lpp,
  input  logic [VPW_W-1:0]  cfg_vpw,
  input  logic [WBL_W-1:0]  cfg_wbl,
  input  logic [WBF_W-1:0]  cfg_wbf,
  input  logic              cfg_pol_shift,
  input  logic              cfg_pol_hs,
  input  logic              cfg_pol_vs,
  input  logic              cfg_pol_oe,
  output logic              lcd_shift,
  output logic              lcd_hsync,
  output logic              lcd_vsync,
  output logic              lcd_oe,
  output logic [PIX_W:0]    pix_x,
  output logic [LINE_W-1:0] line_y
);
  localparam int HCNT_W = PIX_W + 3;
  localparam int VCNT_W = ((LINE_W > WBF_W) ? LINE_W : WBF_W) + 2;
  localparam int PX_W   = PIX_W + 1;

  typedef struct packed {
    logic              tft;
    logic              dual;
    logic              color;
    logic              wide;
    logic [1:0]        bpp;
    logic [PIX_W-1:0]  ppl;
    logic [LINE_W-1:0] lpp;
    logic [VPW_W-1:0]  vpw;
    logic [WBL_W-1:0]  wbl;
    logic [WBF_W-1:0]  wbf;
    logic [3:0]        pol;   // {oe, vsync, hsync, shift}
  } cfg_t;
  localparam int SH_W = $bits(cfg_t);

  cfg_t cur, sh;
  assign cur = '{tft: cfg_tft, dual: cfg_dual, color: cfg_color, wide: cfg_wide,
                 bpp: cfg_bpp, ppl: cfg_ppl, lpp: cfg_lpp, vpw: cfg_vpw,
                 wbl: cfg_wbl, wbf: cfg_wbf,
                 pol: {cfg_pol_oe, cfg_pol_vs, cfg_pol_hs, cfg_pol_shift}};

  // Timing derived from the captured configuration.
  logic [KW-1:0]     k;
  logic [HCNT_W-1:0] slots, hlen;
  logic [VCNT_W-1:0] front, dlines, vtot;

  assign k      = KW'(rate_k(sh.tft, sh.color, sh.wide, sh.dual, sh.bpp));
  assign slots  = HCNT_W'(data_slots(int'(sh.ppl), sh.tft, sh.wide, sh.dual));
  assign hlen   = slots + HCNT_W'(HS_SLOTS) + HCNT_W'(sh.wbl)
                + HCNT_W'(lead_pad(sh.tft, sh.color, sh.wide, sh.bpp));
  assign front  = sh.tft ? (VCNT_W'(sh.vpw) + VCNT_W'(1)) : '0;
  assign dlines = VCNT_W'(line_rows(int'(sh.lpp), sh.dual));
  assign vtot   = front + dlines + VCNT_W'(sh.wbf);

  // Counters.
  logic              tick, h_last, v_last, line_step, load_evt;
  logic [HCNT_W-1:0] h_cnt;
  logic [VCNT_W-1:0] v_cnt;

  lcd_rate_div #(.KW(KW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(enable), .k(k), .tick(tick)
  );

  lcd_span_ctr #(.W(HCNT_W)) u_hctr (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(tick),
    .limit(hlen), .cnt(h_cnt), .last(h_last)
  );

  assign line_step = tick && h_last;

  lcd_span_ctr #(.W(VCNT_W)) u_vctr (
    .clk(clk), .rst_n(rst_n), .run(enable), .step(line_step),
    .limit(vtot), .cnt(v_cnt), .last(v_last)
  );

  // Configuration capture: continuously while idle, then once per frame end.
  assign load_evt = !enable || (line_step && v_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (load_evt) sh <= cur;
  end

  // Strobe decode, exposed by name for the checker.
  logic hs_act, vs_act, oe_act, data_line;
  assign data_line = enable && (v_cnt >= front) && (v_cnt < (front + dlines));
  assign hs_act    = enable && (h_cnt < HCNT_W'(HS_SLOTS));
  assign vs_act    = enable && (sh.tft ? (v_cnt < front) : (v_cnt == '0));
  assign oe_act    = data_line && (h_cnt >= HCNT_W'(HS_SLOTS))
                   && (h_cnt < (HCNT_W'(HS_SLOTS) + slots));

  logic [3:0] pins;
  lcd_pin_drive #(.N(4)) u_pins (
    .act({oe_act, vs_act, hs_act, tick}),
    .pol(sh.pol),
    .pin(pins)
  );
  assign {lcd_oe, lcd_vsync, lcd_hsync, lcd_shift} = pins;

  logic [HCNT_W-1:0] h_off;
  logic [VCNT_W-1:0] v_off;
  assign h_off  = h_cnt - HCNT_W'(HS_SLOTS);
  assign v_off  = v_cnt - front;
  assign pix_x  = oe_act ? PX_W'(h_off) : '0;
  assign line_y = data_line ? LINE_W'(v_off) : '0;

endmodule

// File: rtl/lcd_scan_timing_chk.sv
module lcd_scan_timing_chk #(
  parameter int HCNT_W = 14,
  parameter int VCNT_W = 12,
  parameter int PX_W   = 12,
  parameter int SH_W   = 8,
  parameter int KW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tick,
  input logic [KW-1:0]     k,
  input logic              hs_act,
  input logic              vs_act,
  input logic              oe_act,
  input logic              tft,
  input logic [HCNT_W-1:0] h_cnt,
  input logic [HCNT_W-1:0] hlen,
  input logic [HCNT_W-1:0] slots,
  input logic [VCNT_W-1:0] v_cnt,
  input logic              load_evt,
  input logic [SH_W-1:0]   sh_bits,
  input logic [PX_W-1:0]   pix_x
);
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (k > KW'(1))) |=> !tick);

  p_hcnt_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (h_cnt < hlen));

  p_vs_oe_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_act && tft) |-> !oe_act);

  p_hs_oe_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_act |-> !oe_act);

  p_pix_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_act |-> (HCNT_W'(pix_x) < slots));

  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load_evt) |=> $stable(sh_bits));

  p_idle_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((h_cnt == '0) && (v_cnt == '0)));
endmodule

bind lcd_scan_timing lcd_scan_timing_chk #(
  .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .PX_W(PX_W), .SH_W(SH_W), .KW(KW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .k(k),
  .hs_act(hs_act), .vs_act(vs_act), .oe_act(oe_act), .tft(sh.tft),
  .h_cnt(h_cnt), .hlen(hlen), .slots(slots), .v_cnt(v_cnt),
  .load_evt(load_evt), .sh_bits(sh), .pix_x(pix_x)
);

// File: tb/lcd_scan_timing_tb.sv
`timescale 1ns/1ps
module lcd_scan_timing_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tft = 0, dual = 0, color = 0, wide = 0;
  logic [1:0]  bpp = 0;
  logic [10:0] ppl = 11'd16;
  logic [9:0]  lpp = 10'd4;
  logic [3:0]  vpw = 0;
  logic [7:0]  wbl = 0;
  logic [9:0]  wbf = 0;
  logic p_sh = 1, p_hs = 1, p_vs = 1, p_oe = 1;
  logic lcd_shift, lcd_hsync, lcd_vsync, lcd_oe;
  logic [11:0] pix_x;
  logic [9:0]  line_y;

  always #2.5 clk = ~clk;

  lcd_scan_timing u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_tft(tft), .cfg_dual(dual), .cfg_color(color), .cfg_wide(wide),
    .cfg_bpp(bpp), .cfg_ppl(ppl), .cfg_lpp(lpp), .cfg_vpw(vpw),
    .cfg_wbl(wbl), .cfg_wbf(wbf),
    .cfg_pol_shift(p_sh), .cfg_pol_hs(p_hs), .cfg_pol_vs(p_vs), .cfg_pol_oe(p_oe),
    .lcd_shift(lcd_shift), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_oe(lcd_oe), .pix_x(pix_x), .line_y(line_y)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  // Frame monitor, sampled at the falling edge.
  int frames = 0, f_len, f_lines, f_vs, f_oe, f_str, f_x0, f_y0, f_mx, f_my;
  int a_len, a_lines, a_vs, a_oe, a_str, a_x0, a_y0, a_mx, a_my;
  int hs_per = 0, hs_w = 0, since = 0, hw_acc = 0;
  bit armed = 0, hs_seen = 0, got_oe = 0, vs_prev = 0, hs_prev = 0;

  always @(negedge clk) begin
    bit vs_a, hs_a, oe_a, sh_a;
    vs_a = (lcd_vsync == p_vs);
    hs_a = (lcd_hsync == p_hs);
    oe_a = (lcd_oe == p_oe);
    sh_a = (lcd_shift == p_sh);
    if (!enable) begin
      armed = 0; frames = 0; hs_seen = 0; vs_prev = 0; hs_prev = 0;
    end else begin
      if (vs_a && !vs_prev) begin
        if (armed) begin
          f_len = a_len; f_lines = a_lines; f_vs = a_vs; f_oe = a_oe; f_str = a_str;
          f_x0 = a_x0; f_y0 = a_y0; f_mx = a_mx; f_my = a_my;
          frames++;
        end
        armed = 1;
        a_len = 0; a_lines = 0; a_vs = 0; a_oe = 0; a_str = 0;
        a_x0 = -1; a_y0 = -1; a_mx = -1; a_my = -1; got_oe = 0;
      end
      if (hs_a && !hs_prev) begin
        if (hs_seen) hs_per = since;
        since = 0; hs_seen = 1; a_lines++;
      end
      since++;
      if (hs_a) hw_acc++;
      if (!hs_a && hs_prev) begin hs_w = hw_acc; hw_acc = 0; end
      a_len++;
      if (vs_a) a_vs++;
      if (oe_a) begin
        a_oe++;
        if (sh_a) a_str++;
        if (!got_oe) begin a_x0 = int'(pix_x); a_y0 = int'(line_y); got_oe = 1; end
        if (int'(pix_x) > a_mx) a_mx = int'(pix_x);
        if (int'(line_y) > a_my) a_my = int'(line_y);
      end
      vs_prev = vs_a; hs_prev = hs_a;
    end
  end

  // Expected timing, restated from the requirements.
  int e_k, e_sl, e_hl, e_dl, e_tot, e_vsl;
  function automatic void expect_cfg();
    int bw, p, n;
    bw  = tft ? 1 : (wide ? 8 : 4);
    p   = dual ? 2 * int'(ppl) : int'(ppl);
    e_sl = p / bw;
    n   = (!tft && !color && !wide && (bpp == 2'd1 || bpp == 2'd2)) ? 7 : 5;
    e_k = 1;
    if (!tft && color && bpp == 2'd2) begin
      if (wide) e_k = dual ? 2 : 3;
      else      e_k = dual ? 1 : 2;
    end
    e_hl  = e_sl + 12 + int'(wbl) + n;
    e_dl  = dual ? int'(lpp) / 2 : int'(lpp);
    e_tot = (tft ? int'(vpw) + 1 : 0) + e_dl + int'(wbf);
    e_vsl = tft ? int'(vpw) + 1 : 1;
  endfunction

  task automatic wait_frames(int n);
    int g = 0;
    while (frames < n && g < 40000) begin @(posedge clk); g++; end
    if (g >= 40000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog frames: actual %0d expected %0d", frames, n);
    end
  endtask

  task automatic start_run();
    @(posedge clk); #1 enable = 0;
    repeat (3) @(posedge clk);
    #1 enable = 1;
  endtask

  task automatic check_frame(string s);
    expect_cfg();
    chk({s, " R1 cycles per strobe"}, (f_str == 0) ? 0 : f_oe / f_str, e_k);
    chk({s, " R2 line period"}, hs_per, e_k * e_hl);
    chk({s, " R4 frame cycles"}, f_len, e_k * e_hl * e_tot);
    chk({s, " R4 lines per frame"}, f_lines, e_tot);
    chk({s, " R5 vsync cycles"}, f_vs, e_k * e_hl * e_vsl);
    chk({s, " R6 hsync width"}, hs_w, 12 * e_k);
    chk({s, " R7 oe cycles"}, f_oe, e_k * e_sl * e_dl);
    chk({s, " R7 strobes in oe"}, f_str, e_sl * e_dl);
    chk({s, " R9 first x"}, f_x0, 0);
    chk({s, " R9 first y"}, f_y0, 0);
    chk({s, " R9 last x"}, f_mx, e_sl - 1);
    chk({s, " R9 last y"}, f_my, e_dl - 1);
  endtask

  task automatic setcfg(bit t, bit d, bit c, bit w, int b, int p, int l,
                        int v, int wl, int wf);
    @(posedge clk); #1;
    tft = t; dual = d; color = c; wide = w; bpp = 2'(b);
    ppl = 11'(p); lpp = 10'(l); vpw = 4'(v); wbl = 8'(wl); wbf = 10'(wf);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 reset shift idle", lcd_shift, 1);
    chk("R11 reset hsync idle", lcd_hsync, 1);
    chk("R11 reset vsync idle", lcd_vsync, 1);
    chk("R11 reset oe idle", lcd_oe, 1);
    repeat (2) @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 idle polarity high shift", lcd_shift, 0);
    chk("R8 idle polarity high oe", lcd_oe, 0);
    chk("R11 idle pix_x", int'(pix_x), 0);
    chk("R11 idle line_y", int'(line_y), 0);
  endtask

  task automatic t_tft();
    setcfg(1, 0, 1, 0, 3, 20, 4, 2, 3, 2);
    start_run(); wait_frames(2); check_frame("tft");
  endtask

  task automatic t_color_k3();
    setcfg(0, 0, 1, 1, 2, 48, 4, 0, 1, 2);
    start_run(); wait_frames(2); check_frame("color8 single K3");
  endtask

  task automatic t_color_dual();
    setcfg(0, 1, 1, 1, 2, 24, 6, 0, 0, 1);
    start_run(); wait_frames(2); check_frame("color8 dual K2");
    chk("R3 dual slots from doubled pixels", f_mx + 1, 48 / 8);
    chk("R3 dual lines halved", f_my + 1, 3);
  endtask

  task automatic t_mono_n7();
    setcfg(0, 0, 0, 0, 1, 16, 3, 0, 0, 1);
    start_run(); wait_frames(2); check_frame("mono4 N7");
  endtask

  task automatic t_color4_k2();
    setcfg(0, 0, 1, 0, 2, 8, 3, 0, 2, 0);
    start_run(); wait_frames(2); check_frame("color4 single K2");
  endtask

  task automatic t_polarity();
    setcfg(1, 0, 0, 0, 0, 6, 3, 15, 0, 0);
    #0 p_sh = 0; p_hs = 0; p_vs = 0; p_oe = 0;
    start_run(); wait_frames(2); check_frame("R8 low-active tft vpw16");
    @(posedge clk); #1 enable = 0;
    @(negedge clk);
    chk("R8 low-active idle hsync", lcd_hsync, 1);
    chk("R8 low-active idle vsync", lcd_vsync, 1);
    setcfg(1, 0, 0, 0, 0, 6, 3, 15, 0, 0);
    #0 p_sh = 1; p_hs = 1; p_vs = 1; p_oe = 1;
  endtask

  task automatic t_disable();
    setcfg(1, 0, 0, 0, 0, 10, 4, 0, 1, 1);
    start_run(); wait_frames(1);
    repeat (37) @(posedge clk);
    #1 enable = 0;
    @(negedge clk);
    chk("R11 off shift", lcd_shift, 0);
    chk("R11 off hsync", lcd_hsync, 0);
    chk("R11 off vsync", lcd_vsync, 0);
    chk("R11 off oe", lcd_oe, 0);
    chk("R11 off pix_x", int'(pix_x), 0);
    start_run(); wait_frames(2); check_frame("R11 restart");
  endtask

  task automatic t_midframe();
    setcfg(0, 0, 0, 0, 1, 16, 5, 0, 2, 1);
    start_run(); wait_frames(1);
    repeat (40) @(posedge clk);
    #1 wbl = 8'd9;
    wait_frames(2);
    chk("R10 frame in progress keeps old length", f_len, 25 * 6);
    wait_frames(3);
    chk("R10 next frame uses new length", f_len, 32 * 6);
  endtask

  initial begin
    t_reset();
    t_tft();
    t_color_k3();
    t_color_dual();
    t_mono_n7();
    t_color4_k2();
    t_polarity();
    t_disable();
    t_midframe();
    finish_run();
  end
endmodule